// File: doc/BRIEF.md
# Comparator Output Sample Filter

This block cleans up the single-bit decision of an analog comparator before it reaches software or other logic. The raw decision and an optional external sample clock are asynchronous to the bus clock, so both are brought in through multi-flop synchronizers. A set of control inputs then chooses how the synchronized decision reaches the output. It can follow the comparator directly. It can be frozen outside a window. It can be resampled at a fixed bus-clock interval or on external sample-clock edges. It can also require a run of identical samples before the output is allowed to change.

The control fields are ordinary input ports and are expected to stay steady while the block is enabled. Dropping the enable clears the output and all filter state, which makes that the normal way to restart after reprogramming. Window gating and external sampling are never requested together.

Top module: `cmp_filt`

## Requirements
- R1: While `en_i` is low, `cout_o` reads 0 one clock later, and the divider, run counter, last sample and filtered value are cleared. After re-enabling, the block behaves as if it had just come out of reset.
- R2: Direct mode applies when `filt_cnt_i` is 0, or when `filt_per_i` is 0 with `smp_en_i` low. With `win_en_i` low, `cout_o` equals the level `cmp_i` had three bus clocks earlier: two synchronizer stages plus one output register.
- R3: In direct mode with `win_en_i` high, the output register loads the synchronized comparator level on clocks where `win_i` is high and holds its value on clocks where `win_i` is low.
- R4: With `filt_cnt_i` = 1, `smp_en_i` low and `filt_per_i` = P > 0, a strobe occurs on every P-th bus clock, counted from the first enabled clock. At each strobe the filtered value takes the synchronized comparator level.
- R5: With `filt_cnt_i` = N > 1, the filtered value changes to a level only once N consecutive strobes have sampled that level. The run counter saturates at its maximum value, 2^CNT_W - 1. Between strobes the filtered value is unchanged.
- R6: With `smp_en_i` high and `filt_cnt_i` > 0, strobes come from rising edges of the synchronized external sample clock, and `filt_per_i` is ignored.
- R7: In sampled or filtered mode with `win_en_i` high, strobes are counted only while `win_i` is high. `cout_o` is a further register that copies the filtered value on clocks where `win_i` is high, which adds one bus clock of latency. Outside windowed operation, `cout_o` shows the filtered value directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmp_i | input | 1 | Raw comparator decision, asynchronous |
| smp_clk_i | input | 1 | External sample clock, asynchronous |
| win_i | input | 1 | Window open, synchronous to clk_i |
| en_i | input | 1 | Block enable; low clears all state |
| win_en_i | input | 1 | Window gating enable |
| smp_en_i | input | 1 | Select external sample clock as strobe source |
| filt_cnt_i | input | CNT_W | Consecutive samples required (0 = direct) |
| filt_per_i | input | PER_W | Internal sample period in bus clocks |
| cout_o | output | 1 | Conditioned comparator output |

## Verification
A bad divider count shows up as output transitions that land one or more clocks away from the multiple of the period. The per-clock comparison catches this on the first level change after the error. A corrupted run counter or last-sample register makes the output switch too early or too late, on the strobe where the run completes. A window leak shows up as an output change on a clock where the window is closed. A failure to clear on disable shows up as a nonzero output one clock after the enable drops.

// File: rtl/cmp_filt_pkg.sv
package cmp_filt_pkg;

  typedef enum logic {
    MODE_DIRECT = 1'b0,
    MODE_SAMPLED = 1'b1
  } mode_e;

  function automatic mode_e decode_mode(input logic cnt_zero,
                                        input logic per_zero,
                                        input logic smp_en);
    if (cnt_zero || (per_zero && !smp_en)) return MODE_DIRECT;
    return MODE_SAMPLED;
  endfunction

endpackage

// File: rtl/cmp_filt_sync.sv
module cmp_filt_sync #(
  parameter int W = 2,
  parameter int N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] stg_q [N];

  for (genvar g = 0; g < N; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[g] <= '0;
        else         stg_q[g] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[g] <= '0;
        else         stg_q[g] <= stg_q[g-1];
      end
    end
  end

  assign q_o = stg_q[N-1];

endmodule

// File: rtl/cmp_filt_strobe.sv
module cmp_filt_strobe #(
  parameter int PER_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             smp_en_i,
  input  logic [PER_W-1:0] per_i,
  input  logic             smp_s_i,
  output logic             strb_o
);

  logic [PER_W-1:0] div_q;
  logic             prev_q;
  logic             ext_edge;
  logic             div_run;
  logic             div_wrap;

  assign ext_edge = smp_s_i & ~prev_q;
  assign div_run  = en_i && !smp_en_i && (per_i != '0);
  assign div_wrap = div_q >= (per_i - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= smp_s_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       div_q <= '0;
    else if (!div_run) div_q <= '0;
    else if (div_wrap) div_q <= '0;
    else               div_q <= div_q + 1'b1;
  end

  assign strb_o = smp_en_i ? ext_edge : (div_run && div_wrap);

endmodule

// File: rtl/cmp_filt_core.sv
module cmp_filt_core #(
  parameter int CNT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             gate_i,
  input  logic             smp_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             filt_o,
  output logic [CNT_W-1:0] run_o
);

  localparam logic [CNT_W-1:0] RUN_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] RUN_ONE = CNT_W'(1);

  logic             last_q;
  logic             filt_q;
  logic [CNT_W-1:0] run_q;
  logic [CNT_W-1:0] run_nx;

  always_comb begin
    if (smp_i != last_q)      run_nx = RUN_ONE;
    else if (run_q == RUN_MAX) run_nx = run_q;
    else                       run_nx = run_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_q <= 1'b0;
      run_q  <= '0;
      filt_q <= 1'b0;
    end else if (!en_i) begin
      last_q <= 1'b0;
      run_q  <= '0;
      filt_q <= 1'b0;
    end else if (gate_i) begin
      last_q <= smp_i;
      run_q  <= run_nx;
      if (run_nx >= cnt_i) filt_q <= smp_i;
    end
  end

  assign filt_o = filt_q;
  assign run_o  = run_q;

endmodule

// File: rtl/cmp_filt.sv
module cmp_filt
  import cmp_filt_pkg::*;
#(
  parameter int CNT_W  = 3,
  parameter int PER_W  = 8,
  parameter int SYNC_N = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmp_i,
  input  logic             smp_clk_i,
  input  logic             win_i,
  input  logic             en_i,
  input  logic             win_en_i,
  input  logic             smp_en_i,
  input  logic [CNT_W-1:0] filt_cnt_i,
  input  logic [PER_W-1:0] filt_per_i,
  output logic             cout_o
);

  logic [1:0]       raw;
  logic [1:0]       syncd;
  logic             cmp_s;
  logic             smp_s;
  logic             strb;
  logic             smp_gate;
  logic             win_ok;
  logic             filt_q;
  logic [CNT_W-1:0] run_q;
  logic             out_q;
  mode_e            mode;

  assign raw = {smp_clk_i, cmp_i};

  cmp_filt_sync #(.W(2), .N(SYNC_N)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw),
    .q_o   (syncd)
  );

  assign cmp_s = syncd[0];
  assign smp_s = syncd[1];

  assign mode   = decode_mode(filt_cnt_i == '0, filt_per_i == '0, smp_en_i);
  assign win_ok = !win_en_i || win_i;

  cmp_filt_strobe #(.PER_W(PER_W)) u_strobe (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (en_i),
    .smp_en_i(smp_en_i),
    .per_i   (filt_per_i),
    .smp_s_i (smp_s),
    .strb_o  (strb)
  );

  assign smp_gate = en_i && strb && (mode == MODE_SAMPLED) && win_ok;

  cmp_filt_core #(.CNT_W(CNT_W)) u_core (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (en_i),
    .gate_i(smp_gate),
    .smp_i (cmp_s),
    .cnt_i (filt_cnt_i),
    .filt_o(filt_q),
    .run_o (run_q)
  );

  // direct path register, also the extra window stage in sampled modes
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         out_q <= 1'b0;
    else if (!en_i)      out_q <= 1'b0;
    else if (mode == MODE_DIRECT) begin
      if (win_ok) out_q <= cmp_s;
    end else if (win_en_i && win_i) out_q <= filt_q;
  end

  assign cout_o = (mode == MODE_DIRECT || win_en_i) ? out_q : filt_q;

endmodule

// File: rtl/cmp_filt_chk.sv
module cmp_filt_chk #(
  parameter int CNT_W = 3,
  parameter int PER_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic             win_i,
  input logic             win_en_i,
  input logic             smp_en_i,
  input logic [CNT_W-1:0] filt_cnt_i,
  input logic [PER_W-1:0] filt_per_i,
  input logic             cout_o,
  input logic             cmp_s_i,
  input logic             filt_q_i,
  input logic [CNT_W-1:0] run_q_i,
  input logic             gate_i
);

  logic direct_now;
  assign direct_now = (filt_cnt_i == '0) || (!smp_en_i && filt_per_i == '0);

  a_r1_disable_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !cout_o);

  a_r2_direct_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && direct_now && !win_en_i) |=>
      (!direct_now || cout_o == $past(cmp_s_i)));

  a_r3_window_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && win_en_i && !win_i) |=> (!win_en_i || $stable(cout_o)));

  a_r5_stable_between_strobes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !gate_i) |=> $stable(filt_q_i));

  a_r5_run_before_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> (filt_q_i == $past(filt_q_i) || run_q_i >= $past(filt_cnt_i)));

  a_r7_gate_needs_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gate_i && win_en_i) |-> win_i);

endmodule

bind cmp_filt cmp_filt_chk #(.CNT_W(CNT_W), .PER_W(PER_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .en_i      (en_i),
  .win_i     (win_i),
  .win_en_i  (win_en_i),
  .smp_en_i  (smp_en_i),
  .filt_cnt_i(filt_cnt_i),
  .filt_per_i(filt_per_i),
  .cout_o    (cout_o),
  .cmp_s_i   (cmp_s),
  .filt_q_i  (filt_q),
  .run_q_i   (run_q),
  .gate_i    (smp_gate)
);

// File: tb/cmp_filt_bench.sv
`timescale 1ns/1ps
module cmp_filt_bench;

  localparam int CNT_W = 3;
  localparam int PER_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmp = 1'b0, smp_clk = 1'b0, win = 1'b0, en = 1'b0;
  logic win_en = 1'b0, smp_en = 1'b0;
  logic [CNT_W-1:0] cnt = '0;
  logic [PER_W-1:0] per = '0;
  logic cout;

  int n_cmp = 0, n_bad = 0;
  string cur_req = "R1";

  always #5 clk = ~clk;

  cmp_filt #(.CNT_W(CNT_W), .PER_W(PER_W)) u_cmp_filt (
    .clk_i(clk), .rst_ni(rst_n), .cmp_i(cmp), .smp_clk_i(smp_clk),
    .win_i(win), .en_i(en), .win_en_i(win_en), .smp_en_i(smp_en),
    .filt_cnt_i(cnt), .filt_per_i(per), .cout_o(cout)
  );

  // behavioural reference model
  bit cq[$];      // comparator delay line, oldest first
  bit sq[$];      // sample clock delay line
  int m_div, m_run;
  bit m_last, m_filt, m_out, m_prev;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cq = '{0, 0}; sq = '{0, 0};
      m_div = 0; m_run = 0; m_last = 0; m_filt = 0; m_out = 0; m_prev = 0;
    end else begin
      bit cs, ss, strb, direct, wok, f_old;
      int nr;
      cs = cq[0]; ss = sq[0];
      direct = (cnt == 0) || (!smp_en && per == 0);
      wok = !win_en || win;
      f_old = m_filt;
      if (!en) begin
        m_div = 0; m_run = 0; m_last = 0; m_filt = 0; m_out = 0;
      end else begin
        strb = 0;
        if (smp_en) begin
          strb = ss && !m_prev;
          m_div = 0;
        end else if (per == 0) m_div = 0;
        else if (m_div >= int'(per) - 1) begin
          m_div = 0; strb = 1;
        end else m_div++;
        if (strb && !direct && wok) begin
          nr = (cs == m_last) ? ((m_run < 7) ? m_run + 1 : 7) : 1;
          m_last = cs; m_run = nr;
          if (nr >= int'(cnt)) m_filt = cs;
        end
        if (direct) begin
          if (wok) m_out = cs;
        end else if (win_en && win) m_out = f_old;
      end
      m_prev = ss;
      void'(cq.pop_front()); cq.push_back(cmp);
      void'(sq.pop_front()); sq.push_back(smp_clk);
    end
  end

  function automatic bit model_out();
    bit direct;
    direct = (cnt == 0) || (!smp_en && per == 0);
    return (direct || win_en) ? m_out : m_filt;
  endfunction

  task automatic check(input string req, input bit act, input bit exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: cout=%0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  // per-clock comparison, before inputs move
  always @(negedge clk) if (rst_n) check(cur_req, cout, model_out());

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
    end
  endtask

  task automatic restart(input bit we, input bit se, input int c, input int p);
    @(negedge clk); #1; en = 0;
    tick(2);
    win_en = we; smp_en = se; cnt = CNT_W'(c); per = PER_W'(p);
    en = 1;
  endtask

  task automatic wander(input int n, input int hold, input bit do_win, input int sclk);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
      if ($urandom_range(hold - 1, 0) == 0) cmp = ~cmp;
      if (do_win && $urandom_range(3, 0) == 0) win = ~win;
      if (sclk > 0 && (i % sclk) == 0) smp_clk = ~smp_clk;
    end
  endtask

  bit done = 0;
  initial begin
    #1500000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: timeout actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1;
    @(negedge clk);
    cur_req = "R1";
    check("R1", cout, 1'b0);  // reset state

    // R2 directed latency: 3 clocks from cmp_i to cout_o
    restart(0, 0, 0, 5);
    cur_req = "R2";
    tick(6);
    cmp = 1;
    @(negedge clk); @(negedge clk); check("R2", cout, 1'b0); #1;
    @(negedge clk); check("R2", cout, 1'b1); #1;
    wander(60, 3, 0, 0);
    restart(0, 0, 3, 0);
    wander(40, 2, 0, 0);

    // R3 windowed direct
    restart(1, 0, 0, 0);
    cur_req = "R3";
    wander(120, 2, 1, 0);

    // R4 resample every 4 clocks
    restart(0, 0, 1, 4);
    cur_req = "R4";
    wander(120, 5, 0, 0);

    // R5 directed: count 3, strobe every clock
    cmp = 0;
    restart(0, 0, 3, 1);
    cur_req = "R5";
    tick(6);
    cmp = 1;
    for (int i = 0; i < 4; i++) @(negedge clk);
    check("R5", cout, 1'b0);
    @(negedge clk); check("R5", cout, 1'b1); #1;
    wander(100, 4, 0, 0);
    restart(0, 0, 4, 2);
    wander(120, 6, 0, 0);
    restart(0, 0, 7, 1);   // saturating run counter
    wander(150, 12, 0, 0);

    // R6 external sample clock, period ignored
    restart(0, 1, 3, 0);
    cur_req = "R6";
    wander(150, 8, 0, 3);
    restart(0, 1, 1, 9);
    wander(100, 5, 0, 2);

    // R7 windowed sampled and filtered
    restart(1, 0, 2, 3);
    cur_req = "R7";
    wander(150, 4, 1, 0);
    restart(1, 0, 1, 2);
    wander(120, 3, 1, 0);

    // R1 drop enable mid-run
    cur_req = "R1";
    cmp = 1;
    tick(10);
    en = 0;
    @(negedge clk); check("R1", cout, 1'b0); #1;
    en = 1; tick(20);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule